// File: doc/BRIEF.md
# Destructive-Read Core Memory Cycle Sequencer

This block sequences accesses to a coincident-current magnetic-core style word array, where every read erases the word it reads. A request port with a valid/ready handshake carries an address, a two-bit cycle kind and write data. Every accepted access runs in two halves.

The first half is the read. It selects the word and drives it towards the erased (zero) state, and it captures the per-bit flux-change flags from the sense lines as read data. The second half is the write. It reverses the drive polarity and raises inhibit on each bit that must stay erased, which stores the intended word.

Three kinds of cycle are offered:
- Restore puts the sensed word back.
- Clear-write discards the sensed word and stores new data.
- Read-modify-write returns the sensed word, then holds until the client supplies the replacement word.

A parameter removes read-modify-write. A fixed recovery gap follows each access before the port accepts again.

Top module: `core_cycle_seq`

## Requirements
- R1: While a half cycle drives the array, exactly one X line and one Y line are high. The X index is the low ADDR_W/2 address bits and the Y index is the remaining upper bits. No line is high at any other time, and no other word of the array changes.
- R2: The read half lasts PULSE_CLKS cycles with drivePol low and no inhibit. senseStrobe is high only in the read cycle at offset SENSE_OFS (0 = first read cycle). rspData equals senseIn as captured in that cycle.
- R3: The write half lasts PULSE_CLKS cycles with drivePol high. inhibit[i] is high exactly when bit i of the word to be stored is 0.
- R4: Kind 2'b00 (restore) stores the sensed word again, so the array word is unchanged. rspDone pulses for one cycle in cycle 2*PULSE_CLKS, counted from the acceptance edge (cycle 0 = the first read cycle).
- R5: Kind 2'b01 (clear-write) returns the old word on rspData, stores reqWdata, and uses the same done timing as R4.
- R6: Kind 2'b10 (read-modify-write) pulses rspDone in cycle PULSE_CLKS with the old word on rspData. It then holds with rmwWait high, reqReady low and no drive until rmwValid is seen. After that it runs the write half, which stores rmwData, and gives no second done pulse.
- R7: Kind 2'b11 is rejected. So is kind 2'b10 when RMW_EN is 0. A rejected request is consumed, rspErr pulses in the cycle after the acceptance edge, nothing is driven, and reqReady stays high.
- R8: reqReady is low from the acceptance edge until GAP_CLKS cycles after the last write-half cycle.
- R9: After reset, reqReady is high. All drive lines, inhibit, senseStrobe, rspDone, rspErr and rmwWait are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqAddr | input | ADDR_W | Word address |
| reqType | input | 2 | Cycle kind: 00 restore, 01 clear-write, 10 read-modify-write, 11 reserved |
| reqWdata | input | DATA_W | Data for clear-write |
| rmwValid | input | 1 | Replacement word present during the read-modify-write hold |
| rmwData | input | DATA_W | Replacement word |
| rmwWait | output | 1 | Holding for the replacement word |
| rspData | output | DATA_W | Word sensed in the last read half |
| rspDone | output | 1 | One-cycle pulse: read data available |
| rspErr | output | 1 | One-cycle pulse: request rejected |
| xDrive | output | 2**(ADDR_W/2) | X line drive enables |
| yDrive | output | 2**(ADDR_W-ADDR_W/2) | Y line drive enables |
| drivePol | output | 1 | 0 = read (erase) polarity, 1 = write polarity |
| inhibit | output | DATA_W | Per-bit inhibit during the write half |
| senseStrobe | output | 1 | Sense sampling strobe |
| senseIn | input | DATA_W | Per-bit flux-change flags |

## Verification
The bench models the array as a word store. A read drive erases the word and reports its old bits, and a write drive sets every bit that is not inhibited. Every address is swept with clear-write and then with restore, and the whole array is compared after each access. This exposes a decoder that picks the wrong line, a restore that writes back stale or inverted data, and an inverted inhibit sense. Read-modify-write is run with all-zero and all-one words and a stretched hold, which catches a sequencer that drives during the hold or signals done twice. Rejected kinds, the strobe offset, the half-cycle lengths and the recovery gap are timed cycle by cycle, so a design that drove on a reserved kind or released ready early would show a cycle-count mismatch.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

  typedef enum logic [1:0] {
    CK_RESTORE = 2'b00,
    CK_CLEARWR = 2'b01,
    CK_RMW     = 2'b10,
    CK_RSVD    = 2'b11
  } cycleKind_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic accept;      // latch address and request data
    logic rmwLoad;     // latch replacement word
    logic senseCap;    // capture sense flags
    logic readPhase;   // erase-polarity drive active
    logic writePhase;  // write-polarity drive active
    logic useSense;    // store sensed word (restore kind)
  } seqStrobe_t;

endpackage

// File: rtl/core_seq_ctrl.sv
module core_seq_ctrl
  import core_seq_pkg::*;
#(
  parameter int PULSE_CLKS = 3,
  parameter int SENSE_OFS  = 1,
  parameter int GAP_CLKS   = 2,
  parameter bit RMW_EN     = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqType,
  input  logic       rmwValid,
  output logic       reqReady,
  output logic       rmwWait,
  output logic       drivePol,
  output logic       senseStrobe,
  output logic       rspDone,
  output logic       rspErr,
  output seqStrobe_t stb
);

  localparam int CNT_MAX = (PULSE_CLKS > GAP_CLKS) ? PULSE_CLKS : GAP_CLKS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_HOLD, S_WRITE, S_GAP} seqState_t;

  seqState_t  state;
  logic [CW-1:0] cnt;
  cycleKind_t kindQ;
  logic       doneQ, errQ;
  logic       kindOk, accept, lastPulse, lastGap;

  generate
    if (RMW_EN) begin : g_rmwOn
      assign kindOk = (reqType != CK_RSVD);
    end else begin : g_rmwOff
      assign kindOk = (reqType == CK_RESTORE) || (reqType == CK_CLEARWR);
    end
  endgenerate

  assign accept    = reqValid && (state == S_IDLE);
  assign lastPulse = (cnt == CW'(PULSE_CLKS - 1));
  assign lastGap   = (cnt == CW'(GAP_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      kindQ <= CK_RESTORE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (kindOk) begin
            state <= S_READ;
            cnt   <= '0;
            kindQ <= cycleKind_t'(reqType);
          end else begin
            errQ <= 1'b1;
          end
        end
        S_READ: if (lastPulse) begin
          cnt <= '0;
          if (kindQ == CK_RMW) begin
            state <= S_HOLD;
            doneQ <= 1'b1;
          end else begin
            state <= S_WRITE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_HOLD: if (rmwValid) begin
          state <= S_WRITE;
          cnt   <= '0;
        end
        S_WRITE: if (lastPulse) begin
          cnt   <= '0;
          state <= S_GAP;
          if (kindQ != CK_RMW) doneQ <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_GAP: if (lastGap) begin
          state <= S_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady    = (state == S_IDLE);
  assign rmwWait     = (state == S_HOLD);
  assign drivePol    = (state == S_WRITE);
  assign senseStrobe = (state == S_READ) && (cnt == CW'(SENSE_OFS));
  assign rspDone     = doneQ;
  assign rspErr      = errQ;

  always_comb begin
    stb.accept     = accept && kindOk;
    stb.rmwLoad    = (state == S_HOLD) && rmwValid;
    stb.senseCap   = senseStrobe;
    stb.readPhase  = (state == S_READ);
    stb.writePhase = (state == S_WRITE);
    stb.useSense   = (kindQ == CK_RESTORE);
  end

endmodule

// File: rtl/core_seq_dpath.sv
module core_seq_dpath
  import core_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int XW = ADDR_W / 2,
  localparam int YW = ADDR_W - XW,
  localparam int NX = 1 << XW,
  localparam int NY = 1 << YW
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] rmwData,
  input  logic [DATA_W-1:0] senseIn,
  output logic [NX-1:0]     xDrive,
  output logic [NY-1:0]     yDrive,
  output logic [DATA_W-1:0] inhibit,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wordQ, senseQ, target;
  logic              driveOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wordQ  <= '0;
      senseQ <= '0;
    end else begin
      if (stb.accept) begin
        addrQ <= reqAddr;
        wordQ <= reqWdata;
      end
      if (stb.rmwLoad)  wordQ  <= rmwData;
      if (stb.senseCap) senseQ <= senseIn;
    end
  end

  assign driveOn = stb.readPhase || stb.writePhase;
  assign target  = stb.useSense ? senseQ : wordQ;
  assign inhibit = stb.writePhase ? ~target : '0;
  assign rspData = senseQ;

  generate
    for (genvar i = 0; i < NX; i++) begin : g_x
      assign xDrive[i] = driveOn && (addrQ[XW-1:0] == XW'(i));
    end
    for (genvar j = 0; j < NY; j++) begin : g_y
      assign yDrive[j] = driveOn && (addrQ[ADDR_W-1:XW] == YW'(j));
    end
  endgenerate

endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq
  import core_seq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 4,
  parameter int PULSE_CLKS = 3,
  parameter int SENSE_OFS  = 1,
  parameter int GAP_CLKS   = 2,
  parameter bit RMW_EN     = 1'b1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  output logic                              reqReady,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [1:0]                        reqType,
  input  logic [DATA_W-1:0]                 reqWdata,
  input  logic                              rmwValid,
  input  logic [DATA_W-1:0]                 rmwData,
  output logic                              rmwWait,
  output logic [DATA_W-1:0]                 rspData,
  output logic                              rspDone,
  output logic                              rspErr,
  output logic [(1<<(ADDR_W/2))-1:0]        xDrive,
  output logic [(1<<(ADDR_W-ADDR_W/2))-1:0] yDrive,
  output logic                              drivePol,
  output logic [DATA_W-1:0]                 inhibit,
  output logic                              senseStrobe,
  input  logic [DATA_W-1:0]                 senseIn
);

  seqStrobe_t stb;

  core_seq_ctrl #(
    .PULSE_CLKS(PULSE_CLKS), .SENSE_OFS(SENSE_OFS),
    .GAP_CLKS(GAP_CLKS), .RMW_EN(RMW_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .rmwValid(rmwValid), .reqReady(reqReady), .rmwWait(rmwWait),
    .drivePol(drivePol), .senseStrobe(senseStrobe), .rspDone(rspDone),
    .rspErr(rspErr), .stb(stb)
  );

  core_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rmwData(rmwData), .senseIn(senseIn),
    .xDrive(xDrive), .yDrive(yDrive), .inhibit(inhibit), .rspData(rspData)
  );

endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int NX = 1 << (ADDR_W / 2),
  localparam int NY = 1 << (ADDR_W - ADDR_W / 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rmwWait,
  input logic              rspDone,
  input logic              rspErr,
  input logic [NX-1:0]     xDrive,
  input logic [NY-1:0]     yDrive,
  input logic              drivePol,
  input logic [DATA_W-1:0] inhibit,
  input logic              senseStrobe
);

  AST_ONE_X_LINE: assert property (@(posedge clk) disable iff (!rstN) $onehot0(xDrive)); // R1
  AST_ONE_Y_LINE: assert property (@(posedge clk) disable iff (!rstN) $onehot0(yDrive)); // R1
  AST_XY_TOGETHER: assert property (@(posedge clk) disable iff (!rstN) (|xDrive) == (|yDrive)); // R1
  AST_STROBE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    senseStrobe |-> ((|xDrive) && !drivePol)); // R2
  AST_INHIBIT_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (|inhibit) |-> (drivePol && (|xDrive))); // R3
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rmwWait |-> (!reqReady && xDrive == '0)); // R6
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (reqReady && xDrive == '0)); // R7
  AST_READY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (xDrive == '0 && !senseStrobe)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R4

endmodule

bind core_cycle_seq core_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rmwWait(rmwWait),
  .rspDone(rspDone), .rspErr(rspErr), .xDrive(xDrive), .yDrive(yDrive),
  .drivePol(drivePol), .inhibit(inhibit), .senseStrobe(senseStrobe)
);

// File: tb/core_cycle_seq_tb.sv
module core_cycle_seq_tb;

  localparam int AW = 4, DW = 4, P = 3, OFS = 1, G = 2;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqValid = 1'b0, rmwValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqType = '0;
  logic [DW-1:0] reqWdata = '0, rmwData = '0, senseIn = '0;
  logic          reqReady, rmwWait, rspDone, rspErr, drivePol, senseStrobe;
  logic [DW-1:0] rspData, inhibit;
  logic [3:0]    xDrive, yDrive;

  core_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CLKS(P), .SENSE_OFS(OFS),
                   .GAP_CLKS(G), .RMW_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqType(reqType), .reqWdata(reqWdata),
    .rmwValid(rmwValid), .rmwData(rmwData), .rmwWait(rmwWait),
    .rspData(rspData), .rspDone(rspDone), .rspErr(rspErr), .xDrive(xDrive),
    .yDrive(yDrive), .drivePol(drivePol), .inhibit(inhibit),
    .senseStrobe(senseStrobe), .senseIn(senseIn));

  // Second instance without read-modify-write
  logic          nValid = 1'b0, nReady, nWait, nDone, nErr, nPol, nStrobe;
  logic [1:0]    nType = '0;
  logic [DW-1:0] nData, nInh;
  logic [3:0]    nX, nY;

  core_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CLKS(P), .SENSE_OFS(OFS),
                   .GAP_CLKS(G), .RMW_EN(1'b0)) u_dutNoRmw (
    .clk(clk), .rstN(rstN), .reqValid(nValid), .reqReady(nReady),
    .reqAddr(4'h5), .reqType(nType), .reqWdata(4'h0),
    .rmwValid(1'b0), .rmwData(4'h0), .rmwWait(nWait),
    .rspData(nData), .rspDone(nDone), .rspErr(nErr), .xDrive(nX),
    .yDrive(nY), .drivePol(nPol), .inhibit(nInh),
    .senseStrobe(nStrobe), .senseIn(4'h0));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Array model: erase-on-read, set-unless-inhibited on write
  logic [DW-1:0] arr [16] = '{default: '0};
  logic [DW-1:0] refMem [16] = '{default: '0};
  logic [DW-1:0] senseHold = '0;
  bit  prevRead = 0, badDrive = 0;
  int  readCnt = 0, writeCnt = 0, strobeAt = -1, expAddr = 0;

  always @(negedge clk) begin
    int xi, yi, a;
    xi = 0; yi = 0;
    for (int i = 0; i < 4; i++) begin
      if (xDrive[i]) xi = i;
      if (yDrive[i]) yi = i;
    end
    a = yi * 4 + xi;
    if (|xDrive || |yDrive) begin
      if ($countones(xDrive) != 1 || $countones(yDrive) != 1 || a != expAddr)
        badDrive = 1;
      if (!drivePol) begin
        if (inhibit != 0) badDrive = 1;
        if (senseStrobe) strobeAt = readCnt;
        readCnt++;
        if (!prevRead) begin
          senseHold = arr[a];
          arr[a] = '0;
        end
        prevRead = 1;
        senseIn <= senseHold;
      end else begin
        writeCnt++;
        prevRead = 0;
        arr[a] = ~inhibit;
        senseIn <= '0;
      end
    end else begin
      prevRead = 0;
      senseIn <= '0;
    end
  end

  task automatic access(input logic [3:0] a, input logic [1:0] k,
                        input logic [3:0] wd, input logic [3:0] md, input string req);
    int c;
    logic [3:0] oldW, newW;
    oldW = refMem[a];
    newW = (k == 2'b00) ? oldW : (k == 2'b01) ? wd : md;
    readCnt = 0; writeCnt = 0; strobeAt = -1; badDrive = 0; expAddr = a;
    @(negedge clk);
    check(reqReady == 1'b1, {req, " R8 ready before access"}, reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqType = k; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    c = 0;
    while (!rspDone && c < 40) begin @(negedge clk); c++; end
    check(c == ((k == 2'b10) ? P : 2 * P), {req, " done cycle"}, c, (k == 2'b10) ? P : 2 * P);
    check(rspData == oldW, {req, " R2 read data"}, rspData, oldW);
    if (k == 2'b10) begin
      repeat (3) begin
        @(negedge clk);
        check(rmwWait && !reqReady && xDrive == 0 && !rspDone, "R6 hold quiet", rmwWait, 1);
      end
      rmwValid = 1'b1; rmwData = md;
      @(posedge clk);
      @(negedge clk);
      rmwValid = 1'b0;
      c = 0;
      while (!reqReady && c < 40) begin
        @(negedge clk); c++;
        if (rspDone) check(0, "R6 second done", 1, 0);
      end
      check(c == P + G, "R8 rmw recovery", c, P + G);
    end else begin
      c = 0;
      while (!reqReady && c < 40) begin @(negedge clk); c++; end
      check(c == G, "R8 recovery gap", c, G);
    end
    check(readCnt == P, "R2 read length", readCnt, P);
    check(writeCnt == P, "R3 write length", writeCnt, P);
    check(strobeAt == OFS, "R2 strobe offset", strobeAt, OFS);
    check(!badDrive, "R1 line select", badDrive, 0);
    refMem[a] = newW;
    check(arr[a] == newW, {req, " R3 stored word"}, arr[a], newW);
  endtask

  task automatic arrayCompare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 16; i++) if (arr[i] != refMem[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && xDrive == 0 && yDrive == 0 && inhibit == 0 && !senseStrobe
          && !rspDone && !rspErr && !rmwWait, "R9 reset state", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && xDrive == 0 && !rmwWait, "R9 after release", reqReady, 1);

    for (int a = 0; a < 16; a++) begin
      access(4'(a), 2'b01, 4'((a * 7 + 5) & 15), 4'h0, "R5 clear-write");
      arrayCompare("R1 other words untouched");
    end
    for (int a = 0; a < 16; a++) begin
      access(4'(a), 2'b00, 4'hA, 4'h0, "R4 restore");
      arrayCompare("R4 restore keeps array");
    end
    access(4'h3, 2'b01, 4'h0, 4'h0, "R5 all zero");
    access(4'h3, 2'b00, 4'h0, 4'h0, "R4 restore zero");
    access(4'hC, 2'b01, 4'hF, 4'h0, "R5 all one");
    access(4'hC, 2'b10, 4'h0, 4'h0, "R6 rmw to zero");
    access(4'h3, 2'b10, 4'h0, 4'hF, "R6 rmw to one");
    access(4'h9, 2'b10, 4'h3, 4'h6, "R6 rmw mixed");
    access(4'h9, 2'b00, 4'h0, 4'h0, "R4 restore after rmw");
    arrayCompare("R6 array after rmw");

    // Reserved kind on the main instance
    @(negedge clk);
    reqValid = 1'b1; reqType = 2'b11; reqAddr = 4'h2;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspErr == 1'b1, "R7 reserved err pulse", rspErr, 1);
    check(reqReady && xDrive == 0, "R7 reserved no drive", xDrive, 0);
    @(negedge clk);
    check(rspErr == 1'b0 && xDrive == 0, "R7 err single pulse", rspErr, 0);
    arrayCompare("R7 reserved leaves array");

    // Read-modify-write kind on the instance without it
    @(negedge clk);
    nValid = 1'b1; nType = 2'b10;
    @(posedge clk);
    @(negedge clk);
    nValid = 1'b0;
    check(nErr == 1'b1 && nReady, "R7 rmw disabled rejected", nErr, 1);
    @(negedge clk);
    check(nErr == 1'b0 && nX == 0 && !nWait, "R7 rmw disabled no cycle", nX, 0);
    nValid = 1'b1; nType = 2'b01;
    @(posedge clk);
    @(negedge clk);
    nValid = 1'b0;
    check(nErr == 1'b0 && !nReady && nX == 4'b0010 && nY == 4'b0010,
          "R1 decode on reduced instance", nX, 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule